// File: doc/BRIEF.md
# Privileged Interrupt Router and Arbiter

This block decides, in one combinational pass, whether a hart must take an interrupt. It takes three raw interrupt sources: software, timer and external. It also takes the machine delegation image, the interrupt enable image, the two global enable bits (machine and supervisor), the current privilege level and a flag that says a valid instruction is available to be redirected. From these it builds a twelve-bit pending image. It then filters the pending bits against the enables and the privilege rules, picks one winner by a fixed priority, and reports the trap cause and the privilege level that must handle the trap.

Delegation only adds supervisor-level pending bits. It never removes the machine-level ones. A hart that runs in machine mode with machine interrupts globally enabled therefore still takes an interrupt that has been handed to the supervisor.

Top module: `irq_route_arbiter`

## Requirements
- R1: Pending bits 11, 7 and 3 always equal the raw external, timer and software inputs, whatever the delegation image holds.
- R2: Pending bits 9, 5 and 1 are 1 only when the raw external, timer or software input is 1 and delegation bit 9, 5 or 1 is also 1. All other pending bits are 0.
- R3: An interrupt can be taken only when its pending bit and the matching bit of the enable image are both 1. Enable bits at other positions have no effect.
- R4: At privilege code 3 (machine), any candidate is taken when the machine global enable is 1, including a supervisor-level one, and none is taken when it is 0. The target privilege is then 3.
- R5: At privilege codes 0, 1 and 2, a machine-level candidate (bits 11, 7, 3) is taken whatever the global enables hold, with target privilege 3.
- R6: A supervisor-level candidate (bits 9, 5, 1) is taken at privilege code 1 only when the supervisor global enable is 1. At codes 0 and 2 it is always taken. Below machine its target privilege is 1.
- R7: Among allowed candidates the winner is, from highest priority: bit 11, bit 3, bit 7, bit 9, bit 1, bit 5.
- R8: When an interrupt is taken, cause bit XLEN-1 is 1. Cause bits 3:2 hold the type (0 software, 1 timer, 2 external) and bits 1:0 hold the level (1 supervisor, 3 machine). All other cause bits are 0, so bits 3:0 equal the winner's pending bit index.
- R9: No interrupt is taken while the valid-instruction input is 0.
- R10: When no interrupt is taken, the cause is 0 and the target privilege is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_sw_irq | input | 1 | Raw software interrupt |
| i_timer_irq | input | 1 | Raw timer interrupt |
| i_ext_irq | input | 1 | Raw external interrupt |
| i_deleg | input | 12 | Machine interrupt delegation image |
| i_irq_en | input | 12 | Interrupt enable image |
| i_mie_global | input | 1 | Machine global interrupt enable |
| i_sie_global | input | 1 | Supervisor global interrupt enable |
| i_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| i_instr_valid | input | 1 | A valid instruction is available to redirect |
| o_pending | output | 12 | Pending interrupt image |
| o_take | output | 1 | Take an interrupt now |
| o_cause | output | XLEN | Trap cause of the winning interrupt |
| o_target_priv | output | 2 | Privilege level that handles the trap |

## Verification
Two functions can act in the same evaluation. One is the machine-level route, which ignores delegation. The other is the supervisor-level route, which delegation opens. When a raw source is delegated, both bits of that type become pending together. Priority and the privilege rules then have to choose between them, and in machine mode a lone supervisor-level candidate, whose machine twin is masked, must still be taken. The bench sweeps every combination of the raw sources, delegation, the six relevant enable bits, both global enables, all four privilege codes and the valid flag. It judges each of the four outputs against a model written from the requirements.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   localparam int IRQ_W   = 12;
   localparam int NSRC    = 6;
   localparam int SLOT_W  = $clog2(NSRC);

   typedef enum logic [1:0] {
      PRIV_USER  = 2'd0,
      PRIV_SUPER = 2'd1,
      PRIV_RSVD  = 2'd2,
      PRIV_MACH  = 2'd3
   } priv_e;

   // Pending bit index served by each priority slot, slot 0 highest.
   function automatic logic [3:0] slot_code(input int slot);
      case (slot)
         0:       slot_code = 4'd11;
         1:       slot_code = 4'd3;
         2:       slot_code = 4'd7;
         3:       slot_code = 4'd9;
         4:       slot_code = 4'd1;
         default: slot_code = 4'd5;
      endcase
   endfunction

   // Low two bits of the code carry the level: 3 machine, 1 supervisor.
   function automatic logic code_is_machine(input logic [3:0] code);
      code_is_machine = (code[1:0] == 2'd3);
   endfunction

endpackage

// File: rtl/irq_pending_build.sv
module irq_pending_build
   import irq_route_pkg::*;
#(
   parameter bit HAS_SMODE = 1'b1
) (
   input  logic              sw_irq,
   input  logic              timer_irq,
   input  logic              ext_irq,
   input  logic [IRQ_W-1:0]  deleg,
   output logic [IRQ_W-1:0]  pend
);

   logic [IRQ_W-1:0] unused_deleg;
   assign unused_deleg = deleg;

   logic [IRQ_W-1:0] mach_bits;
   logic [IRQ_W-1:0] sup_bits;

   always_comb begin
      mach_bits     = '0;
      mach_bits[11] = ext_irq;
      mach_bits[7]  = timer_irq;
      mach_bits[3]  = sw_irq;
   end

   generate
      if (HAS_SMODE) begin : g_smode
         always_comb begin
            sup_bits    = '0;
            sup_bits[9] = ext_irq   & deleg[9];
            sup_bits[5] = timer_irq & deleg[5];
            sup_bits[1] = sw_irq    & deleg[1];
         end
      end else begin : g_no_smode
         assign sup_bits = '0;
      end
   endgenerate

   assign pend = mach_bits | sup_bits;

endmodule

// File: rtl/irq_candidate_filter.sv
module irq_candidate_filter
   import irq_route_pkg::*;
(
   input  logic [IRQ_W-1:0] pend,
   input  logic [IRQ_W-1:0] en,
   input  logic             mie_global,
   input  logic             sie_global,
   input  logic [1:0]       priv,
   output logic [NSRC-1:0]  allowed
);

   logic unused_en;
   assign unused_en = ^{en[10], en[8], en[6], en[4], en[2], en[0]};

   logic in_mach;
   logic in_super;
   assign in_mach  = (priv == PRIV_MACH);
   assign in_super = (priv == PRIV_SUPER);

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_slot
         localparam logic [3:0] CODE    = slot_code(s);
         localparam bit         MLEVEL  = code_is_machine(CODE);
         logic cand;
         logic gate;
         assign cand = pend[CODE] & en[CODE];
         if (MLEVEL) begin : g_m
            assign gate = in_mach ? mie_global : 1'b1;
         end else begin : g_s
            assign gate = in_mach ? mie_global : (in_super ? sie_global : 1'b1);
         end
         assign allowed[s] = cand & gate;
      end
   endgenerate

endmodule

// File: rtl/irq_priority_pick.sv
module irq_priority_pick
   import irq_route_pkg::*;
(
   input  logic [NSRC-1:0]   req,
   output logic              hit,
   output logic [SLOT_W-1:0] slot
);

   always_comb begin
      hit  = 1'b0;
      slot = '0;
      for (int s = NSRC - 1; s >= 0; s--) begin
         if (req[s]) begin
            hit  = 1'b1;
            slot = SLOT_W'(s);
         end
      end
   end

   always_comb begin
      if (hit) assert_winner_req_R7: assert (req[slot])
         else $error("winner slot not requesting");
      if (hit) assert_winner_top_R7: assert ((req & ((NSRC'(1) << slot) - NSRC'(1))) == '0)
         else $error("higher priority slot skipped");
   end

endmodule

// File: rtl/irq_route_arbiter.sv
module irq_route_arbiter
   import irq_route_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter bit HAS_SMODE = 1'b1
) (
   input  logic               i_sw_irq,
   input  logic               i_timer_irq,
   input  logic               i_ext_irq,
   input  logic [IRQ_W-1:0]   i_deleg,
   input  logic [IRQ_W-1:0]   i_irq_en,
   input  logic               i_mie_global,
   input  logic               i_sie_global,
   input  logic [1:0]         i_priv,
   input  logic               i_instr_valid,
   output logic [IRQ_W-1:0]   o_pending,
   output logic               o_take,
   output logic [XLEN-1:0]    o_cause,
   output logic [1:0]         o_target_priv
);

   localparam int CAUSE_PAD = XLEN - 5;

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("XLEN must be 32 or 64");
      end
   endgenerate

   logic [NSRC-1:0]   allowed;
   logic              hit;
   logic [SLOT_W-1:0] win_slot;
   logic [3:0]        win_code;

   irq_pending_build #(.HAS_SMODE(HAS_SMODE)) u_pend (
      .sw_irq    (i_sw_irq),
      .timer_irq (i_timer_irq),
      .ext_irq   (i_ext_irq),
      .deleg     (i_deleg),
      .pend      (o_pending)
   );

   irq_candidate_filter u_filt (
      .pend       (o_pending),
      .en         (i_irq_en),
      .mie_global (i_mie_global),
      .sie_global (i_sie_global),
      .priv       (i_priv),
      .allowed    (allowed)
   );

   irq_priority_pick u_pick (
      .req  (allowed),
      .hit  (hit),
      .slot (win_slot)
   );

   assign win_code = slot_code(int'(win_slot));
   assign o_take   = hit & i_instr_valid;

   always_comb begin
      if (o_take) begin
         o_cause       = {1'b1, {CAUSE_PAD{1'b0}}, win_code};
         o_target_priv = (i_priv == PRIV_MACH || code_is_machine(win_code))
                         ? PRIV_MACH : PRIV_SUPER;
      end else begin
         o_cause       = '0;
         o_target_priv = PRIV_MACH;
      end
   end

   always_comb begin
      assert_sup_implies_mach_R2: assert ((o_pending[9] -> o_pending[11]) &&
                                          (o_pending[5] -> o_pending[7]) &&
                                          (o_pending[1] -> o_pending[3]))
         else $error("supervisor pending bit without machine twin");
      if (o_take) assert_take_needs_valid_R9: assert (i_instr_valid)
         else $error("take without valid instruction");
      if (o_take && i_priv == PRIV_MACH) assert_mach_needs_mie_R4: assert (i_mie_global)
         else $error("machine mode take with global enable clear");
      if (o_take) assert_cause_enabled_R3: assert (o_cause[XLEN-1] &&
                                                    o_pending[o_cause[3:0]] &&
                                                    i_irq_en[o_cause[3:0]])
         else $error("cause names a non-candidate");
      if (o_take && o_target_priv == PRIV_SUPER) assert_sup_target_R6: assert (i_priv != PRIV_MACH)
         else $error("supervisor target while in machine mode");
      if (!o_take) assert_idle_outputs_R10: assert (o_cause == '0 && o_target_priv == PRIV_MACH)
         else $error("idle outputs wrong");
   end

endmodule

// File: tb/tb_irq_route_arbiter.sv
module tb_irq_route_arbiter;

   localparam int XLEN = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic             sw, tmr, ext;
   logic [11:0]      deleg, en;
   logic             mie, sie, valid;
   logic [1:0]       priv;
   logic [11:0]      pending;
   logic             take;
   logic [XLEN-1:0]  cause;
   logic [1:0]       tpriv;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   irq_route_arbiter #(.XLEN(XLEN)) dut (
      .i_sw_irq (sw), .i_timer_irq (tmr), .i_ext_irq (ext),
      .i_deleg (deleg), .i_irq_en (en),
      .i_mie_global (mie), .i_sie_global (sie),
      .i_priv (priv), .i_instr_valid (valid),
      .o_pending (pending), .o_take (take),
      .o_cause (cause), .o_target_priv (tpriv)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (priv %0d valid %0d mie %0d sie %0d raw %b deleg %h en %h)",
                  req, act, exp, priv, valid, mie, sie, {ext, tmr, sw}, deleg, en);
      end
   endtask

   // Model written from the requirements.
   task automatic judge();
      logic [11:0] ep;
      int          order [6];
      logic        hit;
      int          code;
      logic        etake;
      logic [63:0] ecause;
      logic [1:0]  etp;
      order = '{11, 3, 7, 9, 1, 5};
      ep     = '0;
      ep[11] = ext;  ep[7] = tmr;  ep[3] = sw;                        // R1
      ep[9]  = ext & deleg[9]; ep[5] = tmr & deleg[5]; ep[1] = sw & deleg[1]; // R2
      hit = 1'b0; code = 0;
      for (int k = 0; k < 6; k++) begin
         int  b;
         bit  mlevel, ok;
         b = order[k];
         mlevel = (b % 4 == 3);
         if (priv == 2'd3) ok = mie;                                  // R4
         else if (mlevel) ok = 1'b1;                                  // R5
         else ok = (priv == 2'd1) ? sie : 1'b1;                       // R6
         if (!hit && ep[b] && en[b] && ok) begin                      // R3, R7
            hit = 1'b1; code = b;
         end
      end
      etake  = hit & valid;                                           // R9
      ecause = etake ? ((64'd1 << (XLEN-1)) | 64'(code)) : 64'd0;     // R8, R10
      etp    = !etake ? 2'd3 : ((priv == 2'd3 || code % 4 == 3) ? 2'd3 : 2'd1);
      check("R1 R2 pending", 64'(pending), 64'(ep));
      check("R3 R4 R5 R6 R9 take", 64'(take), 64'(etake));
      check("R7 R8 R10 cause", 64'(cause), ecause);
      check("R4 R5 R6 R10 target", 64'(tpriv), 64'(etp));
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 195000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      sw = 0; tmr = 0; ext = 0; deleg = '0; en = '0;
      mie = 0; sie = 0; valid = 0; priv = 2'd0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state: all quiet, R10 idle outputs.
      check("R10 reset take", 64'(take), 64'd0);
      check("R10 reset cause", 64'(cause), 64'd0);
      check("R10 reset target", 64'(tpriv), 64'd3);
      check("R1 reset pending", 64'(pending), 64'd0);
      for (int p = 0; p < 4; p++)
         for (int v = 0; v < 2; v++)
            for (int g = 0; g < 4; g++)
               for (int r = 0; r < 8; r++)
                  for (int d = 0; d < 8; d++)
                     for (int e = 0; e < 64; e++) begin
                        @(posedge clk);
                        priv  = 2'(p);
                        valid = v[0];
                        mie   = g[0];
                        sie   = g[1];
                        {ext, tmr, sw} = 3'(r);
                        // Machine delegation bits mirror the pattern to show R1 ignores them.
                        deleg = 12'hFFF;
                        deleg[9] = d[2]; deleg[5] = d[1]; deleg[1] = d[0];
                        deleg[11] = d[0]; deleg[7] = d[2]; deleg[3] = d[1];
                        // Unused enable positions driven high to show R3 ignores them.
                        en = 12'b0101_0101_0101;
                        en[11] = e[5]; en[9] = e[4]; en[7] = e[3];
                        en[5]  = e[2]; en[3] = e[1]; en[1] = e[0];
                        @(negedge clk);
                        judge();
                     end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule